// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers the completion and fault events of up to eight DMA channel engines into one 32-bit pending word and reduces that word to a single interrupt request. Every channel can raise three kinds of event: a fault (error), an abort acknowledgement and a finished transfer (terminal count). Each event kind has its own 8-bit lane inside the word. Software reads the word over a small register bus and clears the bits it has handled by writing ones to them. A mask word with the same lane layout decides which pending bits may reach the interrupt line.

The block also holds two per-channel control words. One is a channel-enable word that software writes and reads back, and that drives the engines' enable inputs. The other is an abort word: software writes a bit mask to it, the selected channels receive an abort request for exactly one cycle, and then the word returns to zero by itself.

The event inputs are one-cycle pulses from the channel engines. The bus is a single-cycle write strobe with a 2-bit word address. Reads are combinational and have no side effects.

Top module: `dmairq_status`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and abort words read 0. The mask word reads 1 in every implemented bit, so all sources start masked. `irq` is 0.
- R2: The status word is at address 0. An error pulse on channel c sets bit c, an abort pulse sets bit 8+c and a terminal-count pulse sets bit 16+c. The bit becomes visible on the clock edge that samples the pulse.
- R3: An event pulse sets its status bit whether or not the matching mask bit is set. A status bit stays set until it is cleared.
- R4: A write to address 0 clears every status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R6: The mask word is at address 1 and is read/write, with the same lane layout as the status word. A mask bit of 1 blocks the matching status bit from the interrupt; a mask bit of 0 lets it through.
- R7: `irq` is registered. In each cycle it equals the OR, taken one cycle earlier, of all status bits whose mask bit is 0.
- R8: The enable word is at address 2 and is read/write. A write replaces its low NCH bits, and the word drives `ch_enable`.
- R9: A write to address 3 loads the data mask into the abort word. `ch_abort` shows that mask for exactly one cycle and then returns to 0, unless another write to address 3 follows.
- R10: Bits above the implemented lanes (bits 24 to 31, and lane bits for channels at or above NCH) always read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_err | input | NCH | One-cycle error pulse per channel |
| ev_abt | input | NCH | One-cycle abort-acknowledge pulse per channel |
| ev_tc | input | NCH | One-cycle terminal-count pulse per channel |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word address: 0 status, 1 mask, 2 enable, 3 abort |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| ch_enable | output | NCH | Channel enable bits |
| ch_abort | output | NCH | One-cycle channel abort requests |
| irq | output | 1 | Registered combined interrupt request |

## Verification
Directed patterns come first. Three different event kinds are raised at once, which shows that each lands in its own lane and does not spill into a neighbour. An event is raised while masked, which separates setting the flag from raising the interrupt. Clearing writes that carry only one 1 bit show that the zeros in the data leave other bits untouched. An event pulse and a clearing write are then aimed at the same bit in one cycle, which tells apart a design where the set wins from one where the clear wins. After that, a long random phase mixes sparse pulses on all channels with random writes to all four addresses, and a behavioural model is compared against every output on every cycle. That phase catches mistakes in interrupt timing, in the abort pulse length and in the unimplemented bits.

// File: rtl/dmairq_pkg.sv
// Shared constants and types for the DMA interrupt status collector.
// Assumes a 32-bit register bus with four word addresses.
package dmairq_pkg;
    localparam int unsigned LANE_W  = 8;   // width of one event lane in the status word
    localparam int unsigned N_KINDS = 3;   // error, abort, terminal count
    localparam int unsigned WORD_W  = 32;

    typedef enum logic [1:0] {
        ADDR_STATUS = 2'd0,
        ADDR_MASK   = 2'd1,
        ADDR_ENABLE = 2'd2,
        ADDR_ABORT  = 2'd3
    } reg_addr_e;

    // lane index of each event kind; the lane number times LANE_W is the bit offset
    typedef enum int unsigned {
        KIND_ERR = 0,
        KIND_ABT = 1,
        KIND_TC  = 2
    } ev_kind_e;
endpackage

// File: rtl/dmairq_flag_lane.sv
// One lane of sticky pending flags, one flag per channel.
// Each flag is set by its event pulse and cleared by its clear request.
// Assumes that the set and clear inputs are already qualified by the bus write.
module dmairq_flag_lane #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_set,
    input  logic [NCH-1:0] clr_req,
    output logic [NCH-1:0] flags
);
    // hold flags; a set in the same cycle as a clear leaves the flag set
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_req) | ev_set;
    end

    // R5: a pulse always leaves its flag set, whatever the clear request says
    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_set != '0) |=> ((flags & $past(ev_set)) == $past(ev_set)));
    // R4: a flag cleared without a competing set reads zero next cycle
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_req & ~ev_set) != '0) |=> ((flags & $past(clr_req & ~ev_set)) == '0));
    // R3: a set flag that is not cleared stays set
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & ~clr_req)) == $past(flags & ~clr_req)));
endmodule

// File: rtl/dmairq_irq_merge.sv
// Mask register and registered interrupt reduction.
// Flat vectors are ordered kind-major: bit k*NCH+c is kind k, channel c.
// Assumes the mask write data has already been taken out of the bus lanes.
module dmairq_irq_merge #(
    parameter int unsigned NCH   = 8,
    parameter int unsigned KINDS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mask_wr,
    input  logic [KINDS*NCH-1:0] mask_wdata,
    input  logic [KINDS*NCH-1:0] flags,
    output logic [KINDS*NCH-1:0] mask_q,
    output logic                 irq
);
    logic any_open;

    // mask storage: reset value blocks every source
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (mask_wr) mask_q <= mask_wdata;
    end

    // find any pending flag whose mask is open
    always_comb any_open = |(flags & ~mask_q);

    // register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= any_open;
    end

    // R6: the mask changes only on a mask write
    a_r6_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));
    // R7: irq is raised only after an unmasked flag was pending
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past((flags & ~mask_q) != '0));
endmodule

// File: rtl/dmairq_chan_ctrl.sv
// Channel enable and channel abort words.
// Enable is a plain read/write word; abort is loaded by a write and clears itself next cycle.
// Assumes write strobes are single-cycle and already decoded.
module dmairq_chan_ctrl #(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en_wr,
    input  logic           abt_wr,
    input  logic [NCH-1:0] wdata,
    output logic [NCH-1:0] en_q,
    output logic [NCH-1:0] abt_q
);
    // enable word storage
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    // abort word: loaded by a write, otherwise back to zero
    always_ff @(posedge clk) begin
        if (!rst_n)      abt_q <= '0;
        else if (abt_wr) abt_q <= wdata;
        else             abt_q <= '0;
    end

    // R9: without a new abort write, the abort word is zero next cycle
    a_r9_abort_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !abt_wr |=> (abt_q == '0));
    // R8: the enable word changes only on an enable write
    a_r8_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(en_q));
endmodule

// File: rtl/dmairq_status.sv
// Top of the DMA interrupt status collector.
// Decodes the register bus, places the three event lanes in the status word,
// and connects the mask/interrupt logic and the channel control words.
// Assumes NCH is between 1 and LANE_W, and that event inputs are one-cycle pulses.
module dmairq_status
    import dmairq_pkg::*;
#(
    parameter int unsigned NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ev_err,
    input  logic [NCH-1:0] ev_abt,
    input  logic [NCH-1:0] ev_tc,
    input  logic           bus_wr,
    input  logic [1:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] ch_enable,
    output logic [NCH-1:0] ch_abort,
    output logic           irq
);
    localparam int unsigned FLAT_W = N_KINDS * NCH;

    logic                wr_status, wr_mask, wr_en, wr_abt;
    logic [NCH-1:0]      ev_lane   [N_KINDS];
    logic [FLAT_W-1:0]   flags_flat;
    logic [FLAT_W-1:0]   clr_flat;
    logic [FLAT_W-1:0]   wlane_flat;
    logic [FLAT_W-1:0]   mask_flat;
    logic [WORD_W-1:0]   status_word, mask_word;
    logic [WORD_W-1:0]   unused_wdata;

    // decode the single-cycle write strobe
    always_comb begin
        wr_status = bus_wr && (bus_addr == ADDR_STATUS);
        wr_mask   = bus_wr && (bus_addr == ADDR_MASK);
        wr_en     = bus_wr && (bus_addr == ADDR_ENABLE);
        wr_abt    = bus_wr && (bus_addr == ADDR_ABORT);
    end

    // route each event kind to its lane
    always_comb begin
        ev_lane[KIND_ERR] = ev_err;
        ev_lane[KIND_ABT] = ev_abt;
        ev_lane[KIND_TC]  = ev_tc;
    end

    // per-lane flags, bus slicing and word assembly
    for (genvar k = 0; k < N_KINDS; k++) begin : g_lane
        assign wlane_flat[k*NCH +: NCH] = bus_wdata[k*LANE_W +: NCH];
        assign clr_flat[k*NCH +: NCH]   = wr_status ? bus_wdata[k*LANE_W +: NCH] : '0;

        dmairq_flag_lane #(.NCH(NCH)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_set  (ev_lane[k]),
            .clr_req (clr_flat[k*NCH +: NCH]),
            .flags   (flags_flat[k*NCH +: NCH])
        );
    end

    // place flat flags and masks at their lane offsets, zero elsewhere
    always_comb begin
        status_word = '0;
        mask_word   = '0;
        for (int k = 0; k < int'(N_KINDS); k++) begin
            status_word[k*LANE_W +: NCH] = flags_flat[k*NCH +: NCH];
            mask_word[k*LANE_W +: NCH]   = mask_flat[k*NCH +: NCH];
        end
    end

    // some write data bits have no storage behind them
    assign unused_wdata = bus_wdata;

    dmairq_irq_merge #(.NCH(NCH), .KINDS(N_KINDS)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (wr_mask),
        .mask_wdata (wlane_flat),
        .flags      (flags_flat),
        .mask_q     (mask_flat),
        .irq        (irq)
    );

    dmairq_chan_ctrl #(.NCH(NCH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_wr  (wr_en),
        .abt_wr (wr_abt),
        .wdata  (bus_wdata[NCH-1:0]),
        .en_q   (ch_enable),
        .abt_q  (ch_abort)
    );

    // read multiplexer, no side effects
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_STATUS: bus_rdata = status_word;
            ADDR_MASK:   bus_rdata = mask_word;
            ADDR_ENABLE: bus_rdata[NCH-1:0] = ch_enable;
            ADDR_ABORT:  bus_rdata[NCH-1:0] = ch_abort;
            default:     bus_rdata = '0;
        endcase
    end

    // R2: an error pulse on channel 0 appears at status bit 0 on the next cycle
    a_r2_err_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err[0] |=> status_word[0]);
    // R2: a terminal-count pulse on channel 0 appears at bit 16
    a_r2_tc_lane0: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tc[0] |=> status_word[2*LANE_W]);
    // R10: bits above the lanes never read as one
    a_r10_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[WORD_W-1:N_KINDS*LANE_W] == '0);
endmodule

// File: tb/dmairq_status_tb.sv
// Cycle-by-cycle behavioural model of the collector, compared on every clock.
module dmairq_status_tb;
    localparam int NCH = 8;
    localparam logic [31:0] VALID = 32'h00FF_FFFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  ev_err = '0, ev_abt = '0, ev_tc = '0;
    logic            bus_wr = 1'b0;
    logic [1:0]      bus_addr = 2'd0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ch_enable, ch_abort;
    logic            irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // model state
    logic [31:0] m_st = '0, m_mk = VALID;
    logic [7:0]  m_en = '0, m_ab = '0;
    logic        m_irq = 1'b0;

    always #10 clk = ~clk;

    dmairq_status #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_err(ev_err), .ev_abt(ev_abt), .ev_tc(ev_tc),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ch_enable(ch_enable), .ch_abort(ch_abort), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_st;
            2'd1: return m_mk;
            2'd2: return {24'd0, m_en};
            default: return {24'd0, m_ab};
        endcase
    endfunction

    // drive one cycle of stimulus, compare outputs, advance the model
    task automatic step(input logic [7:0] e, input logic [7:0] a, input logic [7:0] t,
                        input logic w, input logic [1:0] ad, input logic [31:0] d);
        logic [31:0] set_v, clr_v;
        @(negedge clk);
        ev_err = e; ev_abt = a; ev_tc = t;
        bus_wr = w; bus_addr = ad; bus_wdata = d;
        #1;
        case (ad)
            2'd0: chk("R2 status word", bus_rdata, m_read(ad));
            2'd1: chk("R6 mask word", bus_rdata, m_read(ad));
            2'd2: chk("R8 enable word", bus_rdata, m_read(ad));
            default: chk("R9 abort word", bus_rdata, m_read(ad));
        endcase
        chk("R7 irq", {31'd0, irq}, {31'd0, m_irq});
        chk("R8 ch_enable", {24'd0, ch_enable}, {24'd0, m_en});
        chk("R9 ch_abort", {24'd0, ch_abort}, {24'd0, m_ab});
        set_v = {8'd0, t, a, e};
        clr_v = (w && ad == 2'd0) ? (d & VALID) : 32'd0;
        m_irq = |(m_st & ~m_mk & VALID);
        m_st  = (m_st & ~clr_v) | set_v;
        if (w && ad == 2'd1) m_mk = d & VALID;
        if (w && ad == 2'd2) m_en = d[7:0];
        m_ab = (w && ad == 2'd3) ? d[7:0] : 8'd0;
    endtask

    task automatic rd(input logic [1:0] ad);
        step(8'd0, 8'd0, 8'd0, 1'b0, ad, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(2'd0); chk("R1 status after reset", bus_rdata, 32'd0);
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(2'd1); chk("R1 mask after reset", bus_rdata, VALID);
        rd(2'd2); chk("R1 enable after reset", bus_rdata, 32'd0);
        // R2 lanes, R3 set while masked
        step(8'h04, 8'h20, 8'h80, 1'b0, 2'd0, 32'd0);
        rd(2'd0); chk("R2 lane placement", bus_rdata, 32'h0080_2004);
        rd(2'd0); chk("R3 masked flag gives no irq", {31'd0, irq}, 32'd0);
        // R6/R7 unmask error ch2
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd1, 32'h00FF_FFFB);
        rd(2'd0);
        rd(2'd0); chk("R7 irq after unmask", {31'd0, irq}, 32'd1);
        // R4 clear abort ch5 only
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd0, 32'h0000_2000);
        rd(2'd0); chk("R4 w1c leaves zero-written bits", bus_rdata, 32'h0080_0004);
        // R5 set and clear on the same bit
        step(8'h04, 8'd0, 8'd0, 1'b1, 2'd0, 32'h0000_0004);
        rd(2'd0); chk("R5 set wins over clear", bus_rdata, 32'h0080_0004);
        // clear all, irq falls
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        rd(2'd0); chk("R4 clear all", bus_rdata, 32'd0);
        rd(2'd0); chk("R7 irq falls after clear", {31'd0, irq}, 32'd0);
        // R10 unimplemented bits
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd1, 32'hFFFF_FFFF);
        rd(2'd1); chk("R10 mask upper bits read zero", bus_rdata, VALID);
        // R8 enable
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd2, 32'hFFFF_FFA5);
        rd(2'd2); chk("R8 enable readback", bus_rdata, 32'h0000_00A5);
        // R9 abort pulse
        step(8'd0, 8'd0, 8'd0, 1'b1, 2'd3, 32'h0000_003C);
        rd(2'd3); chk("R9 abort issued", {24'd0, ch_abort}, 32'h3C);
        rd(2'd3); chk("R9 abort self-clears", {24'd0, ch_abort}, 32'h0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] e, a, t;
            logic w;
            e = 8'd0; a = 8'd0; t = 8'd0;
            if ($urandom_range(0, 3) == 0) e = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) a = 8'(1 << $urandom_range(0, 7));
            if ($urandom_range(0, 3) == 0) t = 8'(1 << $urandom_range(0, 7));
            w = ($urandom_range(0, 3) == 0);
            step(e, a, t, w, 2'($urandom_range(0, 3)), $urandom);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule